// File: doc/BRIEF.md
# Parallel EEPROM Page-Write Controller

This block is a clocked behavioural model of the write-control and status logic of a byte-wide nonvolatile memory. It samples active-low chip-select, read-strobe and write-strobe inputs, an address bus and a data bus, all already synchronous to `clk`. Byte loads are collected into a page buffer. The slot inside the page comes from the low address bits, and the page number comes from the bits above them.

The page stays open while new loads keep arriving. Once no new load has started for `LOAD_WIN` cycles and no write strobe is active, a self-timed programming phase of `PROG_CYCLES` cycles begins. At the end of that phase, only the slots that were loaded are copied into the storage array.

While programming runs, reads do not return array contents. They return a status byte instead. Bit 7 carries the complement of bit 7 of the last byte loaded, and bit 6 flips after every read. A host can therefore poll for completion by either method. The bus drive enable rises only during a read.

The default size is a 2K x 8 array, which keeps elaboration small. Setting `ADDR_W = 13` gives the 8K x 8 organisation.

Top module: `eepg_page_writer`

## Requirements
- R1: A load is taken only while `ceN` and `weN` are both low and `oeN` is high. If `ceN` and `weN` go low while `oeN` is also low, nothing is loaded and no programming phase starts.
- R2: The slot address and page address are sampled in the first cycle in which the write condition of R1 holds, which is the later of the two strobe falls. Address changes made before that cycle or after it have no effect.
- R3: The byte stored is the value of `dIn` in the last cycle in which the write condition held, which is the earlier of the two strobe rises. Data changed after that cycle is not stored.
- R4: The page is `addr[ADDR_W-1:PAGE_BITS]` and the slot is `addr[PAGE_BITS-1:0]`. While a page is open, a load whose page field differs from the open page is ignored. A second load to the same slot replaces the earlier byte.
- R5: Each accepted load start restarts a window of `LOAD_WIN` cycles. Programming begins only after the window has elapsed with no new accepted start and no write strobe active. Before that, reads return array data.
- R6: Programming lasts exactly `PROG_CYCLES` cycles. At its end, the loaded slots of the page are written to the array, and all other locations keep their contents.
- R7: Write strobes that arrive during programming are ignored, and their bytes never reach the array.
- R8: During programming, a read returns status. Bit 7 is the inverse of bit 7 of the last loaded byte, and bits 5..0 read as 0.
- R9: During programming, bit 6 of the status reads 0 on the first read and inverts after each completed read. Once programming ends, reads return array data again.
- R10: `dOe` is high only while `ceN` and `oeN` are both low. Outside programming, `dOut` shows the array byte at `addr`. After reset, every array byte reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rstN | input | 1 | Active-low synchronous reset |
| ceN | input | 1 | Chip select, active low |
| oeN | input | 1 | Read strobe, active low |
| weN | input | 1 | Write strobe, active low |
| addr | input | ADDR_W | Byte address |
| dIn | input | DATA_W | Write data from the host |
| dOut | output | DATA_W | Read data or programming status |
| dOe | output | 1 | Bus drive enable; low means the bus is released |

## Verification
The bench uses several stimulus patterns, and each one separates a different failure. A single-byte write with bit 7 clear shows whether reads during programming carry the inverted polling bit and the toggling bit rather than array data, and whether both stop once the cycle ends. A multi-byte page sequence mixes in an overwrite of one slot, a load aimed at a foreign page and an untouched slot that was programmed earlier. This pattern tells buffer replacement apart from foreign-page rejection and from a whole-page commit. Staggered strobe edges, with the address and data changed between the falls and between the rises, show which edge captures each value. Paced loads, a strobe pattern with the read strobe low, and writes issued during programming confirm that the window restarts, that blocked cycles are not writes, and that writes during the busy phase are dropped.

// File: rtl/eepg_pkg.sv
package eepg_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_PROG
  } ctlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic openPage;   // first accepted load: latch page number
    logic capAddr;    // accepted load start: latch slot
    logic sampleData; // write condition holds: track dIn
    logic storeByte;  // accepted load ends: write held byte to buffer
    logic commit;     // last programming cycle: copy loaded slots
    logic busy;       // programming phase active
    logic toggleBit;  // status bit 6
  } ctlStb_t;

endpackage

// File: rtl/eepg_ctrl.sv
module eepg_ctrl
  import eepg_pkg::*;
#(
  parameter int LOAD_WIN    = 40,
  parameter int PROG_CYCLES = 120
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    ceN,
  input  logic    oeN,
  input  logic    weN,
  input  logic    pageHit,
  output ctlStb_t stb
);

  localparam int WIN_W = $clog2(LOAD_WIN + 1);
  localparam int PRG_W = $clog2(PROG_CYCLES + 1);

  ctlState_t        state;
  logic             wrPrev, rdPrev, accepted, toggleQ;
  logic [WIN_W-1:0] winCnt;
  logic [PRG_W-1:0] prgCnt;

  logic wrAct, rdAct, wrStart, wrEnd, rdEnd, winDone, progDone;

  always_comb begin
    wrAct    = !ceN && !weN && oeN;
    rdAct    = !ceN && !oeN;
    wrStart  = wrAct && !wrPrev;
    wrEnd    = !wrAct && wrPrev;
    rdEnd    = !rdAct && rdPrev;
    winDone  = (state == ST_LOAD) && (winCnt == WIN_W'(LOAD_WIN)) && !wrAct && !wrPrev;
    progDone = (state == ST_PROG) && (prgCnt == PRG_W'(PROG_CYCLES - 1));

    stb.openPage   = (state == ST_IDLE) && wrStart;
    stb.capAddr    = wrStart && ((state == ST_IDLE) || ((state == ST_LOAD) && pageHit));
    stb.sampleData = wrAct;
    stb.storeByte  = wrEnd && accepted;
    stb.commit     = progDone;
    stb.busy       = (state == ST_PROG);
    stb.toggleBit  = toggleQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      wrPrev   <= 1'b0;
      rdPrev   <= 1'b0;
      accepted <= 1'b0;
      toggleQ  <= 1'b0;
      winCnt   <= '0;
      prgCnt   <= '0;
    end else begin
      wrPrev <= wrAct;
      rdPrev <= rdAct;

      if (stb.capAddr)    accepted <= 1'b1;
      else if (wrStart)   accepted <= 1'b0;
      else if (wrEnd)     accepted <= 1'b0;

      if (stb.capAddr) winCnt <= '0;
      else if ((state == ST_LOAD) && (winCnt != WIN_W'(LOAD_WIN))) winCnt <= winCnt + 1'b1;

      if (state == ST_PROG) prgCnt <= prgCnt + 1'b1;
      else                  prgCnt <= '0;

      if (winDone) toggleQ <= 1'b0;
      else if ((state == ST_PROG) && rdEnd) toggleQ <= ~toggleQ;

      case (state)
        ST_IDLE: if (stb.openPage) state <= ST_LOAD;
        ST_LOAD: if (winDone)      state <= ST_PROG;
        ST_PROG: if (progDone)     state <= ST_IDLE;
        default:                   state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/eepg_dpath.sv
module eepg_dpath
  import eepg_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 8,
  parameter int PAGE_BITS = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStb_t           stb,
  input  logic              ceN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dIn,
  output logic              pageHit,
  output logic [DATA_W-1:0] dOut,
  output logic              dOe
);

  localparam int SLOTS = 1 << PAGE_BITS;
  localparam int PG_W  = ADDR_W - PAGE_BITS;
  localparam int DEPTH = 1 << ADDR_W;

  logic [PG_W-1:0]      pageQ;
  logic [PAGE_BITS-1:0] slotQ;
  logic [DATA_W-1:0]    dataHold, lastData;
  logic [DATA_W-1:0]    pageBuf [SLOTS];
  logic [SLOTS-1:0]     slotValid;
  logic [DATA_W-1:0]    mem [DEPTH];

  assign pageHit = (addr[ADDR_W-1:PAGE_BITS] == pageQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageQ     <= '0;
      slotQ     <= '0;
      dataHold  <= '0;
      lastData  <= '0;
      slotValid <= '0;
    end else begin
      if (stb.openPage)   pageQ    <= addr[ADDR_W-1:PAGE_BITS];
      if (stb.capAddr)    slotQ    <= addr[PAGE_BITS-1:0];
      if (stb.sampleData) dataHold <= dIn;
      if (stb.storeByte) begin
        slotValid[slotQ] <= 1'b1;
        lastData         <= dataHold;
      end
      if (stb.commit) slotValid <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.storeByte) pageBuf[slotQ] <= dataHold;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (stb.commit) begin
      for (int s = 0; s < SLOTS; s++)
        if (slotValid[s]) mem[{pageQ, PAGE_BITS'(s)}] <= pageBuf[s];
    end
  end

  always_comb begin
    dOe = !ceN && !oeN;
    if (stb.busy) dOut = {~lastData[DATA_W-1], stb.toggleBit, {(DATA_W-2){1'b0}}};
    else          dOut = mem[addr];
  end

endmodule

// File: rtl/eepg_page_writer.sv
module eepg_page_writer
  import eepg_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int DATA_W      = 8,
  parameter int PAGE_BITS   = 6,
  parameter int LOAD_WIN    = 40,
  parameter int PROG_CYCLES = 120
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] dOut,
  output logic              dOe
);

  ctlStb_t stb;
  logic    pageHit;

  eepg_ctrl #(.LOAD_WIN(LOAD_WIN), .PROG_CYCLES(PROG_CYCLES)) ctrl_i (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .pageHit(pageHit), .stb(stb)
  );

  eepg_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS)) dpath_i (
    .clk(clk), .rstN(rstN), .stb(stb), .ceN(ceN), .oeN(oeN),
    .addr(addr), .dIn(dIn), .pageHit(pageHit), .dOut(dOut), .dOe(dOe)
  );

endmodule

// File: rtl/eepg_page_writer_chk.sv
module eepg_page_writer_chk #(
  parameter int ADDR_W      = 11,
  parameter int DATA_W      = 8,
  parameter int PROG_CYCLES = 120
) (
  input logic              clk,
  input logic              rstN,
  input logic              ceN,
  input logic              oeN,
  input logic              weN,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] dOut,
  input logic              dOe,
  input logic              busy,
  input logic              toggleBit
);

  int unsigned busyCnt;
  logic        rdNow, wrNow;

  assign rdNow = !ceN && !oeN;
  assign wrNow = !ceN && !weN && oeN;

  always_ff @(posedge clk) begin
    if (!rstN)     busyCnt <= 0;
    else if (busy) busyCnt <= busyCnt + 1;
    else           busyCnt <= 0;
  end

  // R6: programming phase has the exact length
  p_prog_len_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyCnt == PROG_CYCLES));

  // R5: programming never starts while a write strobe pair was active
  p_start_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !$past(wrNow));

  // R9: each completed read during programming inverts the toggle bit
  p_toggle_flip_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(rdNow) && !rdNow) |=> (!busy || (toggleBit != $past(toggleBit))));

  // R8: low status bits read zero during programming
  p_status_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    (dOe && busy) |-> (dOut[DATA_W-3:0] == '0));

  // R10: array read data is steady while address and phase are steady
  p_read_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    (dOe && $past(dOe) && $stable(addr) && !busy && !$past(busy)) |-> $stable(dOut));

endmodule

bind eepg_page_writer eepg_page_writer_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES)
) chk_i (
  .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
  .addr(addr), .dOut(dOut), .dOe(dOe),
  .busy(stb.busy), .toggleBit(stb.toggleBit)
);

// File: tb/eepg_page_writer_tb_top.sv
`timescale 1ns/1ps
module eepg_page_writer_tb_top;

  localparam int ADDR_W      = 11;
  localparam int DATA_W      = 8;
  localparam int LOAD_WIN    = 40;
  localparam int PROG_CYCLES = 120;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              ceN = 1'b1, oeN = 1'b1, weN = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] dIn = '0;
  logic [DATA_W-1:0] dOut;
  logic              dOe;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  eepg_page_writer #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BITS(6),
    .LOAD_WIN(LOAD_WIN), .PROG_CYCLES(PROG_CYCLES)
  ) dut_i (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .addr(addr), .dIn(dIn), .dOut(dOut), .dOe(dOe)
  );

  task automatic check(input string req, input int got, input int exp);
    nChecks++;
    if (got != exp) begin
      nFails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wrByte(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    addr = a; dIn = d; ceN = 1'b0; weN = 1'b0;
    repeat (2) @(negedge clk);
    weN = 1'b1; ceN = 1'b1;
    @(negedge clk);
  endtask

  task automatic rdByte(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d, output logic oe);
    @(negedge clk);
    addr = a; ceN = 1'b0; oeN = 1'b0;
    @(negedge clk);
    d = dOut; oe = dOe;
    ceN = 1'b1; oeN = 1'b1;
    @(negedge clk);
  endtask

  task automatic waitProg();
    repeat (LOAD_WIN + PROG_CYCLES + 10) @(negedge clk);
  endtask

  task automatic readCheck(input string req, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] exp);
    logic [DATA_W-1:0] d;
    logic oe;
    rdByte(a, d, oe);
    check(req, int'(d), int'(exp));
  endtask

  // R10: reset contents and drive enable
  task automatic t_reset();
    logic [DATA_W-1:0] d;
    logic oe;
    rdByte(11'h000, d, oe);
    check("R10 reset data", int'(d), 0);
    check("R10 dOe during read", int'(oe), 1);
    @(negedge clk);
    ceN = 1'b1; oeN = 1'b0;
    @(negedge clk);
    check("R10 dOe with ceN high", int'(dOe), 0);
    oeN = 1'b1;
    @(negedge clk);
    check("R10 dOe idle", int'(dOe), 0);
  endtask

  // R8 R9 R6: single byte, polling bits then true data
  task automatic t_single();
    wrByte(11'h005, 8'h25);
    repeat (LOAD_WIN + 5) @(negedge clk);
    readCheck("R8 status first read", 11'h005, 8'h80);
    readCheck("R9 toggle second read", 11'h005, 8'hC0);
    readCheck("R9 toggle third read", 11'h005, 8'h80);
    waitProg();
    readCheck("R6 committed byte", 11'h005, 8'h25);
    readCheck("R9 toggling ceased", 11'h005, 8'h25);
  endtask

  // R4 R6: page load with overwrite, foreign page, preserved slot
  task automatic t_page();
    wrByte(11'h0CA, 8'h11);
    waitProg();
    wrByte(11'h0C0, 8'h31);
    wrByte(11'h0C5, 8'h42);
    wrByte(11'h105, 8'h77);
    wrByte(11'h0C5, 8'h55);
    wrByte(11'h0FF, 8'h66);
    waitProg();
    readCheck("R4 slot 0", 11'h0C0, 8'h31);
    readCheck("R4 slot overwrite", 11'h0C5, 8'h55);
    readCheck("R4 slot 63", 11'h0FF, 8'h66);
    readCheck("R6 unloaded slot kept", 11'h0CA, 8'h11);
    readCheck("R6 untouched slot", 11'h0C1, 8'h00);
    readCheck("R4 foreign page ignored", 11'h105, 8'h00);
  endtask

  // R7: writes during programming dropped
  task automatic t_ignoreProg();
    wrByte(11'h200, 8'h12);
    repeat (LOAD_WIN + 5) @(negedge clk);
    wrByte(11'h201, 8'h34);
    wrByte(11'h200, 8'h99);
    waitProg();
    readCheck("R7 byte kept", 11'h200, 8'h12);
    readCheck("R7 busy write dropped", 11'h201, 8'h00);
    waitProg();
    readCheck("R7 no late program", 11'h201, 8'h00);
  endtask

  // R1: read strobe low blocks write
  task automatic t_oeBlock();
    @(negedge clk);
    addr = 11'h300; dIn = 8'h5A; ceN = 1'b0; oeN = 1'b0; weN = 1'b0;
    repeat (2) @(negedge clk);
    ceN = 1'b1; oeN = 1'b1; weN = 1'b1;
    repeat (LOAD_WIN + 5) @(negedge clk);
    readCheck("R1 no programming started", 11'h300, 8'h00);
    waitProg();
    readCheck("R1 nothing stored", 11'h300, 8'h00);
  endtask

  // R5: loads inside the window keep the page open
  task automatic t_window();
    wrByte(11'h340, 8'h01);
    repeat (LOAD_WIN / 2) @(negedge clk);
    readCheck("R5 still loading", 11'h340, 8'h00);
    wrByte(11'h341, 8'h02);
    repeat (LOAD_WIN / 2) @(negedge clk);
    readCheck("R5 window restarted", 11'h340, 8'h00);
    waitProg();
    readCheck("R5 first load", 11'h340, 8'h01);
    readCheck("R5 second load", 11'h341, 8'h02);
  endtask

  // R2 R3: capture edges
  task automatic t_edges();
    @(negedge clk); addr = 11'h380; dIn = 8'hAA; weN = 1'b0;
    @(negedge clk); addr = 11'h381;
    @(negedge clk); ceN = 1'b0;
    @(negedge clk); addr = 11'h3C2; dIn = 8'hBB;
    @(negedge clk); weN = 1'b1;
    @(negedge clk); dIn = 8'hCC;
    @(negedge clk); ceN = 1'b1;
    waitProg();
    readCheck("R2 address at later fall", 11'h381, 8'hBB);
    readCheck("R2 earlier address unused", 11'h380, 8'h00);
    readCheck("R2 later address unused", 11'h3C2, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_single();
    t_page();
    t_ignoreProg();
    t_oeBlock();
    t_window();
    t_edges();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule